// File: doc/BRIEF.md
# Selectable Frequency Output Generator

This block drives one output pin with a square wave or a fixed level. A 3-bit select field picks the setting. The four fast rates come from a 32768 Hz crystal clock divided by powers of two. The mains-rate wave and the 1 Hz wave come from a 50/60 Hz AC pulse input. When that AC input has not been qualified, the 1 Hz wave is taken from the crystal divider instead. The pin can also be held high or held low.

The block runs on a fast system clock. The crystal clock and the AC pulses are sampled into that clock through two-flop synchronizers and counted on their rising edges. The select field and a battery-enable bit are loaded together by a write strobe. While the chip runs from its battery, the pin is held low unless the battery-enable bit is set.

Every change of source goes through a switchover guard. The guard changes source only while the pin is low, or when the old setting is the static-high level. It commits only when the new source is low, or when the new setting is static high. This keeps runt pulses off the pin.

Top module: `freq_out_gen`

## Requirements
- R1: After reset the pin is low, the stored select is 111 and the stored battery-enable bit is 0, so the pin stays low until a new setting is written.
- R2: Select 000 gives a wave at the crystal rate: one output period for each crystal period.
- R3: Selects 001, 010 and 011 divide the crystal by 2, 4 and 8 (16384, 8192 and 4096 Hz). The crystal edge counter advances by at most one per clock.
- R4: Select 100 gives a wave at the mains rate, following the AC input one period per AC period.
- R5: Select 101 with AC qualified (ac_ok_i = 1) gives a period of 50 AC rising edges when mains60_i = 0 and 60 AC rising edges when mains60_i = 1. The wave is high for the first half of each period.
- R6: Select 101 with AC not qualified (ac_ok_i = 0) gives a period of 2^XCNT_W crystal rising edges, which is 1 Hz at the default width of 15.
- R7: Select 110 holds the pin high and select 111 holds it low.
- R8: While on_bat_i = 1 and the stored battery-enable bit is 0, the pin is low. With the bit set to 1, the selected wave continues on battery.
- R9: The select and battery-enable inputs take effect only in a cycle where cfg_wr_i = 1. At other times they are ignored.
- R10: A change of source, battery gating or 1 Hz origin is committed only while the pin is low, or when leaving static high. So no high pulse is shorter than the shortest high phase of the selected waves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the crystal rate |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_i | input | 1 | 32768 Hz crystal clock, sampled |
| ac_i | input | 1 | 50/60 Hz AC pulse input, sampled |
| ac_ok_i | input | 1 | AC input qualified flag (1 = qualified) |
| mains60_i | input | 1 | Mains rate flag (0 = 50 Hz, 1 = 60 Hz) |
| on_bat_i | input | 1 | Running on battery power |
| cfg_wr_i | input | 1 | Load strobe for select and battery-enable |
| cfg_sel_i | input | 3 | Output select: 000 32768 Hz, 001 16384 Hz, 010 8192 Hz, 011 4096 Hz, 100 mains, 101 1 Hz, 110 high, 111 low |
| cfg_bat_en_i | input | 1 | Keep output active on battery |
| fout_o | output | 1 | Frequency output pin (registered) |

## Verification
The assertions check several things on every cycle:
- The switchover guard moves only while the pin is low or when leaving static high.
- The static levels and the battery-gated state hold the pin at the right value.
- The crystal counter never skips a count.
- The prescaler and tenths counters stay in range.

Some behaviours only the bench scenarios can show:
- The actual periods for each select code.
- The 50 versus 60 edge division.
- The crystal fallback for 1 Hz.
- That a select input without the write strobe leaves the pin unchanged.
- That rapid reselection never produces a short high pulse.

The bench measures these against a behavioural model and against periods computed from the stimulus.

// File: rtl/fog_pkg.sv
// Shared select encodings for the frequency output generator.
package fog_pkg;
    typedef enum logic [2:0] {
        SEL_XTAL   = 3'd0,
        SEL_DIV2   = 3'd1,
        SEL_DIV4   = 3'd2,
        SEL_DIV8   = 3'd3,
        SEL_MAINS  = 3'd4,
        SEL_SEC    = 3'd5,
        SEL_HIGH   = 3'd6,
        SEL_LOW    = 3'd7
    } fsel_e;
endpackage

// File: rtl/fog_sync.sv
// Input synchronizer with rising-edge detect.
// Assumes the sampled signal holds each level for at least two clk cycles.
module fog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    // Shift the raw input through the synchronizer chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d_i};
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fog_xtal_div.sv
// Binary divider clocked by crystal rising edges.
// Outputs the /2, /4 and /8 taps and the top bit as the crystal-derived slow tap.
// Assumes W >= 4.
module fog_xtal_div #(
    parameter int W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    output logic [3:0] tap_o
);
    logic [W-1:0] cnt_q;

    // Count crystal rising edges; wraps at 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (rise_i) cnt_q <= cnt_q + 1'b1;
    end

    assign tap_o = {cnt_q[W-1], cnt_q[2], cnt_q[1], cnt_q[0]};

    // R3
    xcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/fog_ac_div.sv
// Divides AC rising edges to 1 Hz.
// A prescaler of P50 or P60 edges gives tenths; a modulo-SEC counter gives seconds.
// sec_o is high for the first half of each second.
// Assumes mains60_i is quasi-static and synchronous to clk.
module fog_ac_div #(
    parameter int P50 = 5,
    parameter int P60 = 6,
    parameter int SEC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic mains60_i,
    output logic sec_o
);
    localparam int PMAX = (P60 > P50) ? P60 : P50;
    localparam int PW   = $clog2(PMAX + 1);
    localparam int SW   = $clog2(SEC + 1);

    logic [PW-1:0] pre_q;
    logic [SW-1:0] ten_q;
    logic [PW-1:0] pre_lim;
    logic          tick;

    assign pre_lim = mains60_i ? PW'(P60 - 1) : PW'(P50 - 1);
    assign tick    = rise_i && (pre_q >= pre_lim);

    // Prescaler: counts AC edges and wraps at the mains-dependent limit.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (rise_i) pre_q <= tick ? '0 : pre_q + 1'b1;
    end

    // Tenths counter: advances once per prescaler wrap, modulo SEC.
    always_ff @(posedge clk) begin
        if (!rst_n)    ten_q <= '0;
        else if (tick) ten_q <= (ten_q == SW'(SEC - 1)) ? '0 : ten_q + 1'b1;
    end

    assign sec_o = (ten_q < SW'(SEC / 2));

    // R5
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q < PW'(PMAX));
    // R5
    ten_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ten_q < SW'(SEC));
endmodule

// File: rtl/freq_out_gen.sv
// Selectable frequency output generator (top).
// Holds the written configuration and builds the eight candidate sources.
// Commits source changes through a guard so the registered pin never shows a runt.
// Assumes ac_ok_i, mains60_i and on_bat_i are synchronous to clk.
module freq_out_gen
    import fog_pkg::*;
#(
    parameter int XCNT_W      = 15,
    parameter int PRE_50      = 5,
    parameter int PRE_60      = 6,
    parameter int SEC_DIV     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_i,
    input  logic       ac_i,
    input  logic       ac_ok_i,
    input  logic       mains60_i,
    input  logic       on_bat_i,
    input  logic       cfg_wr_i,
    input  logic [2:0] cfg_sel_i,
    input  logic       cfg_bat_en_i,
    output logic       fout_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw_in;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] rise;
    logic [3:0]      xtap;
    logic            ac_sec;

    assign raw_in = {ac_i, xtal_i};

    // Crystal in index 0, AC in index 1.
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        fog_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_in[g]),
            .lvl_o (lvl[g]),
            .rise_o(rise[g])
        );
    end

    fog_xtal_div #(.W(XCNT_W)) u_xdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .rise_i(rise[0]),
        .tap_o (xtap)
    );

    fog_ac_div #(.P50(PRE_50), .P60(PRE_60), .SEC(SEC_DIV)) u_adiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise[1]),
        .mains60_i(mains60_i),
        .sec_o    (ac_sec)
    );

    fsel_e sel_q;
    logic  ben_q;
    fsel_e act_sel_q;
    logic  act_off_q;
    logic  act_qual_q;

    // Configuration register, loaded only on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_LOW;
            ben_q <= 1'b0;
        end else if (cfg_wr_i) begin
            sel_q <= fsel_e'(cfg_sel_i);
            ben_q <= cfg_bat_en_i;
        end
    end

    logic       tgt_off;
    logic [7:0] src_cur;
    logic [7:0] src_new;
    logic       cur_val;
    logic       new_val;
    logic       differ;
    logic       can_leave;
    logic       can_enter;
    logic       do_sw;

    assign tgt_off = on_bat_i & ~ben_q;

    // Candidate source vectors, indexed by select code, for committed and requested 1 Hz origin.
    always_comb begin
        src_cur = {1'b0, 1'b1, (act_qual_q ? ac_sec : xtap[3]), lvl[1],
                   xtap[2], xtap[1], xtap[0], lvl[0]};
        src_new = {1'b0, 1'b1, (ac_ok_i ? ac_sec : xtap[3]), lvl[1],
                   xtap[2], xtap[1], xtap[0], lvl[0]};
    end

    // Switchover guard: decide whether the requested setting may be committed now.
    always_comb begin
        cur_val   = act_off_q ? 1'b0 : src_cur[act_sel_q];
        new_val   = tgt_off ? 1'b0 : src_new[sel_q];
        differ    = (tgt_off != act_off_q) || (sel_q != act_sel_q) || (ac_ok_i != act_qual_q);
        can_leave = !fout_o || (!act_off_q && act_sel_q == SEL_HIGH);
        can_enter = !new_val || (!tgt_off && sel_q == SEL_HIGH);
        do_sw     = differ && can_leave && can_enter;
    end

    // Committed setting and registered output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_off_q  <= 1'b1;
            act_sel_q  <= SEL_LOW;
            act_qual_q <= 1'b0;
            fout_o     <= 1'b0;
        end else begin
            fout_o <= do_sw ? new_val : cur_val;
            if (do_sw) begin
                act_off_q  <= tgt_off;
                act_sel_q  <= sel_q;
                act_qual_q <= ac_ok_i;
            end
        end
    end

    // R10
    sw_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_off_q != $past(act_off_q)) || (act_sel_q != $past(act_sel_q)) ||
         (act_qual_q != $past(act_qual_q)))
        |-> (!$past(fout_o) || $past(!act_off_q && act_sel_q == SEL_HIGH)));
    // R7
    static_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_off_q && act_sel_q == SEL_LOW && $past(!act_off_q && act_sel_q == SEL_LOW))
        |-> !fout_o);
    // R7
    static_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_off_q && act_sel_q == SEL_HIGH && $past(!act_off_q && act_sel_q == SEL_HIGH))
        |-> fout_o);
    // R8
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_off_q && $past(act_off_q)) |-> !fout_o);
endmodule

// File: tb/sim_freq_out_gen.sv
`timescale 1ns/1ps
module sim_freq_out_gen;
    localparam int XW = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ac_ok, mains60, on_bat, cfg_wr, cfg_ben;
    logic [2:0] cfg_sel;
    logic       fout;
    int         xph = 0;
    int         aph = 0;
    logic       xtal, ac;

    always #2.5 clk = ~clk;

    // Stimulus generators: crystal period 4 clocks, AC period 10 clocks.
    always @(negedge clk) begin
        xph <= (xph + 1) % 4;
        aph <= (aph + 1) % 10;
    end
    assign xtal = (xph < 2);
    assign ac   = (aph < 5);

    freq_out_gen #(.XCNT_W(XW)) u0 (
        .clk(clk), .rst_n(rst_n), .xtal_i(xtal), .ac_i(ac), .ac_ok_i(ac_ok),
        .mains60_i(mains60), .on_bat_i(on_bat), .cfg_wr_i(cfg_wr),
        .cfg_sel_i(cfg_sel), .cfg_bat_en_i(cfg_ben), .fout_o(fout)
    );

    int checks = 0;
    int fails  = 0;
    bit mon_on = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    logic [2:0]    m_xs, m_as;
    logic [XW-1:0] m_xc;
    int            m_pc, m_sc;
    logic [2:0]    m_cs, m_sel;
    logic          m_cb, m_off, m_q, m_pin;

    always @(posedge clk) begin : model
        logic xr, ar, tk, toff, cur, nw, sw;
        logic [7:0] s, sn;
        int lim;
        if (!rst_n) begin
            m_xs = 0; m_as = 0; m_xc = 0; m_pc = 0; m_sc = 0;
            m_cs = 7; m_cb = 0; m_off = 1; m_sel = 7; m_q = 0; m_pin = 0;
        end else begin
            xr = m_xs[1] & !m_xs[2];
            ar = m_as[1] & !m_as[2];
            s  = {1'b0, 1'b1, (m_q ? (m_sc < 5) : m_xc[XW-1]), m_as[1],
                  m_xc[2], m_xc[1], m_xc[0], m_xs[1]};
            sn = s;
            sn[5] = ac_ok ? (m_sc < 5) : m_xc[XW-1];
            toff = on_bat && !m_cb;
            cur  = m_off ? 1'b0 : s[m_sel];
            nw   = toff ? 1'b0 : sn[m_cs];
            sw = ((toff != m_off) || (m_cs != m_sel) || (ac_ok != m_q)) &&
                 (!m_pin || (!m_off && m_sel == 6)) &&
                 (!nw || (!toff && m_cs == 6));
            m_pin = sw ? nw : cur;
            if (sw) begin m_off = toff; m_sel = m_cs; m_q = ac_ok; end
            lim = mains60 ? 5 : 4;
            tk = ar && (m_pc >= lim);
            if (tk) m_sc = (m_sc + 1) % 10;
            if (ar) m_pc = tk ? 0 : m_pc + 1;
            if (xr) m_xc = m_xc + 1'b1;
            m_xs = {m_xs[1:0], xtal};
            m_as = {m_as[1:0], ac};
            if (cfg_wr) begin m_cs = cfg_sel; m_cb = cfg_ben; end
        end
    end

    function automatic string tag_of();
        if (m_off) return "R8";
        case (m_sel)
            3'd0:                return "R2";
            3'd1, 3'd2, 3'd3:    return "R3";
            3'd4:                return "R4";
            3'd5:                return m_q ? "R5" : "R6";
            default:             return "R7";
        endcase
    endfunction

    // Per-cycle comparison and shortest-high-run monitor.
    int  run_len  = 0;
    int  min_high = 1000000;
    logic prev_pin = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk(tag_of(), fout, m_pin);
            if (fout) run_len++;
            else if (prev_pin && run_len < min_high) min_high = run_len;
            if (!fout) run_len = 0;
            prev_pin = fout;
        end
    end

    task automatic set_cfg(input logic [2:0] sel, input logic ben);
        @(negedge clk);
        cfg_sel = sel; cfg_ben = ben; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic period(output int p);
        logic pv;
        p = -1;
        pv = fout;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!pv && fout) begin p = 0; break; end
            pv = fout;
        end
        if (p == 0) begin
            pv = fout;
            for (int i = 0; i < 5000; i++) begin
                @(negedge clk);
                p++;
                if (!pv && fout) break;
                pv = fout;
            end
        end
    endtask

    task automatic count_rises(input int n, output int r);
        logic pv;
        r = 0;
        pv = fout;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!pv && fout) r++;
            pv = fout;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int p, r;
        rst_n = 0; ac_ok = 1; mains60 = 0; on_bat = 0;
        cfg_wr = 0; cfg_sel = 0; cfg_ben = 0;
        repeat (4) @(negedge clk);
        chk("R1", fout, 0);
        rst_n = 1;
        mon_on = 1;
        repeat (20) @(negedge clk);
        chk("R1", fout, 0);

        // R9: select and enable presented without the strobe
        cfg_sel = 3'd6; cfg_ben = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9", fout, 0);

        set_cfg(3'd6, 1'b0); repeat (10) @(negedge clk);
        chk("R7", fout, 1);
        set_cfg(3'd7, 1'b0); repeat (10) @(negedge clk);
        chk("R7", fout, 0);

        set_cfg(3'd0, 1'b0); repeat (20) @(negedge clk);
        period(p); chk("R2", p, 4);
        set_cfg(3'd1, 1'b0); repeat (20) @(negedge clk);
        period(p); chk("R3", p, 8);
        set_cfg(3'd2, 1'b0); repeat (20) @(negedge clk);
        period(p); chk("R3", p, 16);
        set_cfg(3'd3, 1'b0); repeat (40) @(negedge clk);
        period(p); chk("R3", p, 32);
        set_cfg(3'd4, 1'b0); repeat (20) @(negedge clk);
        period(p); chk("R4", p, 10);

        set_cfg(3'd5, 1'b0); repeat (600) @(negedge clk);
        period(p); chk("R5", p, 500);
        mains60 = 1'b1; repeat (700) @(negedge clk);
        period(p); chk("R5", p, 600);
        ac_ok = 1'b0; repeat (700) @(negedge clk);
        period(p); chk("R6", p, 256);
        ac_ok = 1'b1; mains60 = 1'b0;

        set_cfg(3'd1, 1'b0);
        on_bat = 1'b1; repeat (50) @(negedge clk);
        count_rises(100, r); chk("R8", r, 0);
        chk("R8", fout, 0);
        set_cfg(3'd1, 1'b1); repeat (20) @(negedge clk);
        period(p); chk("R8", p, 8);
        on_bat = 1'b0;

        // R10: rapid reselection among fast rates and static high
        for (int k = 0; k < 8; k++) begin
            set_cfg((k % 2 == 0) ? 3'd0 : ((k % 4 == 1) ? 3'd6 : 3'd3), 1'b0);
            repeat (3 + k) @(negedge clk);
        end
        repeat (50) @(negedge clk);
        chk("R10", (min_high >= 2) ? 1 : 0, 1);

        mon_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule